// File: doc/BRIEF.md
# Cache Block Maintenance Controller

This block carries out maintenance commands on single cache blocks. Two commands act on a data tag array that holds a three-state coherence code per way: store-back, which writes a dirty block to memory and keeps it resident, and flush, which writes a dirty block back if needed and then drops it. A third command invalidates a set of a separate instruction tag array. Both tag arrays sit inside the block as small register files. A fill port loads entries and a read port exposes them, so the effect of each command can be seen from outside.

A command arrives with an address that has already been translated, two protection-fault flags and a broadcast enable. The block takes one command at a time. It looks up the addressed set and applies the per-state rule. It may then request a writeback through a valid/ready memory port, pulse a bus broadcast, or report a data storage exception instead of touching the cache. A single-cycle done pulse closes every accepted command.

With default parameters an address is 32 bits: 5 offset bits, 3 set-index bits and a 24-bit tag. Each array has 8 sets of 4 ways.

Top module: `blkmaint_top`

## Requirements
- R1: After reset, busy, done, wb_valid, bcast_valid and exc_valid are 0, and every way of both tag arrays reads state 2'b00 (Invalid).
- R2: Store-back (cmd_op 2'b00) that hits a way in state 2'b10 (Modified) raises wb_valid with the block-aligned address (offset bits zero). After the handshake the way reads 2'b01 (Exclusive), and done pulses in the cycle after the handshake edge.
- R3: Store-back that hits a way in state 2'b01, or that misses, requests no writeback and changes no tag state. done pulses in the second cycle after the accept edge.
- R4: Flush (cmd_op 2'b01) that hits a way in state 2'b10 writes the block back as in R2. After the handshake the way reads 2'b00.
- R5: Flush that hits a way in state 2'b01 sets that way to 2'b00 without a writeback. A flush that misses changes nothing. In both cases done pulses in the second cycle after the accept edge.
- R6: A store-back or flush without a fault pulses bcast_valid for one cycle, in the same cycle that done pulses or wb_valid first rises, with bcast_op equal to the command code and the block-aligned address. This happens only if addr_bcast_en was 1 at the accept edge, and it happens for a hit or a miss.
- R7: For a store-back or flush, a block-translation fault takes priority and reports exc_cause 2'b01. A page-translation fault alone reports 2'b10. exc_valid pulses together with done, and there is no tag change, no writeback and no broadcast.
- R8: Instruction invalidation (cmd_op 2'b10) sets every way of the instruction-array set selected by address bits [7:5] to 2'b00 and ignores the tag bits. It ignores both fault flags and the broadcast enable, never raises exc_valid or bcast_valid, and leaves the data array untouched.
- R9: busy is 1 from the accept edge until the edge that raises done. A cmd_valid presented while busy is 1 is not taken and has no effect on either array.
- R10: While wb_valid is 1 and wb_ready is 0, wb_valid and wb_addr stay unchanged and the way keeps state 2'b10. The state update happens only at the handshake edge.
- R11: A command with cmd_op 2'b11 is not accepted: busy and done stay 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 store-back, 01 flush, 10 instruction invalidate, 11 not accepted |
| cmd_addr | input | ADDR_W | Translated address (untranslated index for instruction invalidate) |
| xlat_blk_fault | input | 1 | Block-translation protection fault for this command |
| xlat_page_fault | input | 1 | Page-translation protection fault for this command |
| addr_bcast_en | input | 1 | Allows data commands to be broadcast on the bus |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback request |
| wb_addr | output | ADDR_W | Block-aligned writeback address |
| wb_ready | input | 1 | Memory accepts the writeback |
| bcast_valid | output | 1 | One-cycle bus broadcast pulse |
| bcast_op | output | 2 | Command code being broadcast |
| bcast_addr | output | ADDR_W | Block-aligned broadcast address |
| exc_valid | output | 1 | One-cycle data storage exception pulse |
| exc_cause | output | 2 | 01 block-translation fault, 10 page-translation fault |
| fill_valid | input | 1 | Write one tag entry |
| fill_icache | input | 1 | Fill targets the instruction array when 1 |
| fill_set | input | SET_W | Fill set index |
| fill_way | input | WAY_W | Fill way |
| fill_tag | input | TAG_W | Fill tag value |
| fill_state | input | 2 | Fill state code |
| rd_icache | input | 1 | Read port selects the instruction array when 1 |
| rd_set | input | SET_W | Read set index |
| rd_way | input | WAY_W | Read way |
| rd_tag | output | TAG_W | Tag of the selected entry |
| rd_state | output | 2 | State of the selected entry |

## Verification
The hardest case to reach from the ports is a second command held on cmd_valid during a stalled writeback. It is a flush aimed at a dirty block in another set, and it must leave no trace. The bench holds it there for every cycle of the stall and drops it only in the cycle where wb_ready rises. It then reads the victim block through the read port and expects it to still be Modified. The other stimuli that are hard to reach are these. The broadcast enable and the fault flags are changed right after the accept edge, which shows they are sampled only once. Instruction invalidation is issued with both faults set and a tag that matches nothing, which shows the tag and the faults are ignored.

// File: rtl/blkmaint_pkg.sv
package blkmaint_pkg;
   localparam logic [1:0] ST_INV = 2'b00;
   localparam logic [1:0] ST_EXC = 2'b01;
   localparam logic [1:0] ST_MOD = 2'b10;

   localparam logic [1:0] OP_STORE = 2'b00;
   localparam logic [1:0] OP_FLUSH = 2'b01;
   localparam logic [1:0] OP_IINV  = 2'b10;
   localparam logic [1:0] OP_RSVD  = 2'b11;

   localparam logic [1:0] EXC_NONE  = 2'b00;
   localparam logic [1:0] EXC_BLOCK = 2'b01;
   localparam logic [1:0] EXC_PAGE  = 2'b10;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'b00,
      PH_EXEC  = 2'b01,
      PH_WBACK = 2'b10
   } phase_e;
endpackage

// File: rtl/blkmaint_tagstore.sv
module blkmaint_tagstore
   import blkmaint_pkg::*;
#(
   parameter int SETS  = 8,
   parameter int WAYS  = 4,
   parameter int TAG_W = 24
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fill_en,
   input  logic [$clog2(SETS)-1:0]       fill_set,
   input  logic [$clog2(WAYS)-1:0]       fill_way,
   input  logic [TAG_W-1:0]              fill_tag,
   input  logic [1:0]                    fill_st,
   input  logic                          upd_en,
   input  logic [$clog2(SETS)-1:0]       upd_set,
   input  logic [$clog2(WAYS)-1:0]       upd_way,
   input  logic [1:0]                    upd_st,
   input  logic                          clr_en,
   input  logic [$clog2(SETS)-1:0]       clr_set,
   input  logic [$clog2(SETS)-1:0]       look_set,
   output logic [WAYS-1:0][TAG_W-1:0]    look_tag,
   output logic [WAYS-1:0][1:0]          look_st,
   input  logic [$clog2(SETS)-1:0]       rd_set,
   input  logic [$clog2(WAYS)-1:0]       rd_way,
   output logic [TAG_W-1:0]              rd_tag,
   output logic [1:0]                    rd_st
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("tagstore: SETS must be a power of two and at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("tagstore: WAYS must be a power of two and at least 2");
   end
   if (SET_W < 1 || WAY_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("tagstore: derived widths must be positive");
   end

   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [1:0]       st_q  [SETS][WAYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w] <= '0;
               st_q[s][w]  <= ST_INV;
            end
         end
      end else begin
         if (fill_en) begin
            tag_q[fill_set][fill_way] <= fill_tag;
            st_q[fill_set][fill_way]  <= fill_st;
         end
         if (upd_en) begin
            st_q[upd_set][upd_way] <= upd_st;
         end
         if (clr_en) begin
            for (int w = 0; w < WAYS; w++) begin
               st_q[clr_set][w] <= ST_INV;
            end
         end
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_row
      assign look_tag[w] = tag_q[look_set][w];
      assign look_st[w]  = st_q[look_set][w];
   end

   assign rd_tag = tag_q[rd_set][rd_way];
   assign rd_st  = st_q[rd_set][rd_way];
endmodule

// File: rtl/blkmaint_match.sv
module blkmaint_match
   import blkmaint_pkg::*;
#(
   parameter int WAYS     = 4,
   parameter int TAG_W    = 24,
   parameter bit PICK_LOW = 1'b1
) (
   input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
   input  logic [WAYS-1:0][1:0]       row_st,
   input  logic [TAG_W-1:0]           req_tag,
   output logic                       hit,
   output logic [$clog2(WAYS)-1:0]    hit_way,
   output logic [1:0]                 hit_st
);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = (row_st[w] != ST_INV) && (row_tag[w] == req_tag);
   end

   assign hit = |match;

   if (PICK_LOW) begin : g_low_first
      always_comb begin
         hit_way = '0;
         hit_st  = ST_INV;
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
               hit_way = WAY_W'(w);
               hit_st  = row_st[w];
            end
         end
      end
   end else begin : g_high_first
      always_comb begin
         hit_way = '0;
         hit_st  = ST_INV;
         for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
               hit_way = WAY_W'(w);
               hit_st  = row_st[w];
            end
         end
      end
   end
endmodule

// File: rtl/blkmaint_seq.sv
module blkmaint_seq
   import blkmaint_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5,
   parameter int SET_W  = 3,
   parameter int WAY_W  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   input  logic [1:0]                  cmd_op,
   input  logic [ADDR_W-1:0]           cmd_addr,
   input  logic                        blk_fault,
   input  logic                        page_fault,
   input  logic                        bcast_en,
   input  logic                        hit,
   input  logic [WAY_W-1:0]            hit_way,
   input  logic [1:0]                  hit_st,
   input  logic                        wb_ready,
   output logic [SET_W-1:0]            req_set,
   output logic [ADDR_W-OFF_W-SET_W-1:0] req_tag,
   output logic                        upd_en,
   output logic [SET_W-1:0]            upd_set,
   output logic [WAY_W-1:0]            upd_way,
   output logic [1:0]                  upd_st,
   output logic                        clr_en,
   output logic [SET_W-1:0]            clr_set,
   output logic                        wb_valid,
   output logic [ADDR_W-1:0]           wb_addr,
   output logic                        bcast_valid,
   output logic [1:0]                  bcast_op,
   output logic [ADDR_W-1:0]           bcast_addr,
   output logic                        exc_valid,
   output logic [1:0]                  exc_cause,
   output logic                        busy,
   output logic                        done
);
   localparam int BLK_W = ADDR_W - OFF_W;
   localparam int TAG_W = BLK_W - SET_W;

   if (TAG_W < 1) begin : g_bad_split
      $error("seq: address too narrow for offset and index");
   end

   phase_e            phase_q;
   logic [1:0]        op_q;
   logic [BLK_W-1:0]  blk_q;
   logic              bat_q, pte_q, abe_q;
   logic [WAY_W-1:0]  way_q;
   logic              done_q, exc_q, bc_q;
   logic [1:0]        cause_q;
   logic [OFF_W-1:0]  offset_unused;

   logic accept, data_op, faulted, need_wb, flush_e, wb_hs;
   logic [ADDR_W-1:0] aligned;

   assign offset_unused = cmd_addr[OFF_W-1:0];

   assign accept  = (phase_q == PH_IDLE) && cmd_valid && (cmd_op != OP_RSVD);
   assign data_op = (op_q != OP_IINV);
   assign faulted = bat_q | pte_q;
   assign req_set = blk_q[SET_W-1:0];
   assign req_tag = blk_q[BLK_W-1:SET_W];
   assign aligned = {blk_q, {OFF_W{1'b0}}};

   assign need_wb = (phase_q == PH_EXEC) && data_op && !faulted && hit && (hit_st == ST_MOD);
   assign flush_e = (phase_q == PH_EXEC) && (op_q == OP_FLUSH) && !faulted && hit
                    && (hit_st == ST_EXC);
   assign wb_hs   = (phase_q == PH_WBACK) && wb_ready;

   always_comb begin
      upd_en  = flush_e | wb_hs;
      upd_set = req_set;
      upd_way = (phase_q == PH_WBACK) ? way_q : hit_way;
      upd_st  = (wb_hs && (op_q == OP_STORE)) ? ST_EXC : ST_INV;
      clr_en  = (phase_q == PH_EXEC) && (op_q == OP_IINV);
      clr_set = req_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         op_q    <= OP_STORE;
         blk_q   <= '0;
         bat_q   <= 1'b0;
         pte_q   <= 1'b0;
         abe_q   <= 1'b0;
         way_q   <= '0;
         done_q  <= 1'b0;
         exc_q   <= 1'b0;
         bc_q    <= 1'b0;
         cause_q <= EXC_NONE;
      end else begin
         done_q <= 1'b0;
         exc_q  <= 1'b0;
         bc_q   <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  op_q    <= cmd_op;
                  blk_q   <= cmd_addr[ADDR_W-1:OFF_W];
                  bat_q   <= blk_fault;
                  pte_q   <= page_fault;
                  abe_q   <= bcast_en;
                  phase_q <= PH_EXEC;
               end
            end
            PH_EXEC: begin
               if (need_wb) begin
                  way_q   <= hit_way;
                  phase_q <= PH_WBACK;
               end else begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end
               if (data_op && faulted) begin
                  exc_q   <= 1'b1;
                  cause_q <= bat_q ? EXC_BLOCK : EXC_PAGE;
               end
               if (data_op && !faulted && abe_q) begin
                  bc_q <= 1'b1;
               end
            end
            PH_WBACK: begin
               if (wb_ready) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign wb_valid    = (phase_q == PH_WBACK);
   assign wb_addr     = aligned;
   assign bcast_valid = bc_q;
   assign bcast_op    = op_q;
   assign bcast_addr  = aligned;
   assign exc_valid   = exc_q;
   assign exc_cause   = cause_q;
   assign busy        = (phase_q != PH_IDLE);
   assign done        = done_q;
endmodule

// File: rtl/blkmaint_top.sv
module blkmaint_top
   import blkmaint_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int SETS       = 8,
   parameter int WAYS       = 4,
   parameter bit PICK_LOW   = 1'b1,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int SET_W     = $clog2(SETS),
   localparam int WAY_W     = $clog2(WAYS),
   localparam int TAG_W     = ADDR_W - OFF_W - SET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              xlat_blk_fault,
   input  logic              xlat_page_fault,
   input  logic              addr_bcast_en,
   output logic              busy,
   output logic              done,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   input  logic              wb_ready,
   output logic              bcast_valid,
   output logic [1:0]        bcast_op,
   output logic [ADDR_W-1:0] bcast_addr,
   output logic              exc_valid,
   output logic [1:0]        exc_cause,
   input  logic              fill_valid,
   input  logic              fill_icache,
   input  logic [SET_W-1:0]  fill_set,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [1:0]        fill_state,
   input  logic              rd_icache,
   input  logic [SET_W-1:0]  rd_set,
   input  logic [WAY_W-1:0]  rd_way,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [1:0]        rd_state
);
   if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("top: LINE_BYTES must be a power of two and at least 4");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("top: ADDR_W leaves no tag bits");
   end

   logic [SET_W-1:0]            req_set, clr_set, upd_set;
   logic [TAG_W-1:0]            req_tag;
   logic                        upd_en, clr_en;
   logic [WAY_W-1:0]            upd_way;
   logic [1:0]                  upd_st;
   logic [WAYS-1:0][TAG_W-1:0]  d_row_tag;
   logic [WAYS-1:0][1:0]        d_row_st;
   logic [WAYS-1:0][TAG_W-1:0]  i_row_tag_unused;
   logic [WAYS-1:0][1:0]        i_row_st_unused;
   logic                        hit;
   logic [WAY_W-1:0]            hit_way;
   logic [1:0]                  hit_st;
   logic [TAG_W-1:0]            d_rd_tag, i_rd_tag;
   logic [1:0]                  d_rd_st, i_rd_st;
   logic                        d_fill, i_fill;

   assign d_fill = fill_valid & ~fill_icache;
   assign i_fill = fill_valid &  fill_icache;

   blkmaint_tagstore #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_dtags (
      .clk(clk), .rst_n(rst_n),
      .fill_en(d_fill), .fill_set(fill_set), .fill_way(fill_way),
      .fill_tag(fill_tag), .fill_st(fill_state),
      .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way), .upd_st(upd_st),
      .clr_en(1'b0), .clr_set({SET_W{1'b0}}),
      .look_set(req_set), .look_tag(d_row_tag), .look_st(d_row_st),
      .rd_set(rd_set), .rd_way(rd_way), .rd_tag(d_rd_tag), .rd_st(d_rd_st)
   );

   blkmaint_tagstore #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_itags (
      .clk(clk), .rst_n(rst_n),
      .fill_en(i_fill), .fill_set(fill_set), .fill_way(fill_way),
      .fill_tag(fill_tag), .fill_st(fill_state),
      .upd_en(1'b0), .upd_set({SET_W{1'b0}}), .upd_way({WAY_W{1'b0}}), .upd_st(ST_INV),
      .clr_en(clr_en), .clr_set(clr_set),
      .look_set(req_set), .look_tag(i_row_tag_unused), .look_st(i_row_st_unused),
      .rd_set(rd_set), .rd_way(rd_way), .rd_tag(i_rd_tag), .rd_st(i_rd_st)
   );

   blkmaint_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PICK_LOW(PICK_LOW)) u_match (
      .row_tag(d_row_tag), .row_st(d_row_st), .req_tag(req_tag),
      .hit(hit), .hit_way(hit_way), .hit_st(hit_st)
   );

   blkmaint_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .blk_fault(xlat_blk_fault), .page_fault(xlat_page_fault), .bcast_en(addr_bcast_en),
      .hit(hit), .hit_way(hit_way), .hit_st(hit_st), .wb_ready(wb_ready),
      .req_set(req_set), .req_tag(req_tag),
      .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way), .upd_st(upd_st),
      .clr_en(clr_en), .clr_set(clr_set),
      .wb_valid(wb_valid), .wb_addr(wb_addr),
      .bcast_valid(bcast_valid), .bcast_op(bcast_op), .bcast_addr(bcast_addr),
      .exc_valid(exc_valid), .exc_cause(exc_cause),
      .busy(busy), .done(done)
   );

   assign rd_tag   = rd_icache ? i_rd_tag : d_rd_tag;
   assign rd_state = rd_icache ? i_rd_st  : d_rd_st;
endmodule

// File: rtl/blkmaint_chk.sv
module blkmaint_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              wb_valid,
   input logic              wb_ready,
   input logic [ADDR_W-1:0] wb_addr,
   input logic              bcast_valid,
   input logic              exc_valid,
   input logic [1:0]        exc_cause
);
   // R9: completion leaves the block idle
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9: done is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: a writeback request only exists inside a command
   a_r2_wb_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> busy);

   // R10: a stalled writeback holds request and address
   a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

   // R10: a completed writeback ends only through the handshake
   a_r10_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(wb_valid)) |-> $past(wb_ready));

   // R7: exactly one cause is reported
   a_r7_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> ($countones(exc_cause) == 1));

   // R7: an exception completes the command in the same cycle
   a_r7_exc_done: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> done);

   // R7: a faulted command is not broadcast
   a_r7_exc_no_bcast: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !bcast_valid);

   // R6: broadcast appears with completion or with the first writeback cycle
   a_r6_bcast_timing: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid |-> (done || wb_valid));
endmodule

bind blkmaint_top blkmaint_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
   .bcast_valid(bcast_valid), .exc_valid(exc_valid), .exc_cause(exc_cause)
);

// File: tb/tb_blkmaint_top.sv
module tb_blkmaint_top;
   localparam int ADDR_W = 32;
   localparam int OFF_W  = 5;
   localparam int SETS   = 8;
   localparam int WAYS   = 4;
   localparam int SET_W  = 3;
   localparam int WAY_W  = 2;
   localparam int TAG_W  = 24;

   localparam logic [1:0] C_STORE = 2'b00;
   localparam logic [1:0] C_FLUSH = 2'b01;
   localparam logic [1:0] C_IINV  = 2'b10;

   localparam int TA = 24'h0A0A01;
   localparam int TB = 24'h0B0B02;
   localparam int TC = 24'h0C0C03;
   localparam int TD = 24'h0D0D04;
   localparam int TZ = 24'h0E0E05;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic xlat_blk_fault = 1'b0, xlat_page_fault = 1'b0, addr_bcast_en = 1'b0;
   logic busy, done, wb_valid, bcast_valid, exc_valid;
   logic [ADDR_W-1:0] wb_addr, bcast_addr;
   logic wb_ready = 1'b0;
   logic [1:0] bcast_op, exc_cause;
   logic fill_valid = 1'b0, fill_icache = 1'b0;
   logic [SET_W-1:0] fill_set = '0;
   logic [WAY_W-1:0] fill_way = '0;
   logic [TAG_W-1:0] fill_tag = '0;
   logic [1:0] fill_state = '0;
   logic rd_icache = 1'b0;
   logic [SET_W-1:0] rd_set = '0;
   logic [WAY_W-1:0] rd_way = '0;
   logic [TAG_W-1:0] rd_tag;
   logic [1:0] rd_state;

   int m_dst [SETS][WAYS];
   int m_dtag[SETS][WAYS];
   int m_ist [SETS][WAYS];
   int m_itag[SETS][WAYS];
   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #10 clk = ~clk;

   blkmaint_top dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .xlat_blk_fault(xlat_blk_fault), .xlat_page_fault(xlat_page_fault),
      .addr_bcast_en(addr_bcast_en), .busy(busy), .done(done),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
      .bcast_valid(bcast_valid), .bcast_op(bcast_op), .bcast_addr(bcast_addr),
      .exc_valid(exc_valid), .exc_cause(exc_cause),
      .fill_valid(fill_valid), .fill_icache(fill_icache), .fill_set(fill_set),
      .fill_way(fill_way), .fill_tag(fill_tag), .fill_state(fill_state),
      .rd_icache(rd_icache), .rd_set(rd_set), .rd_way(rd_way),
      .rd_tag(rd_tag), .rd_state(rd_state)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_tests++;
         n_fail++;
         $display("FAIL R9 watchdog: actual no completion expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int set, input int off);
      return {TAG_W'(tag), SET_W'(set), OFF_W'(off)};
   endfunction

   task automatic fill(input bit ic, input int set, input int way, input int tag, input int st);
      @(negedge clk);
      fill_valid = 1'b1; fill_icache = ic; fill_set = SET_W'(set);
      fill_way = WAY_W'(way); fill_tag = TAG_W'(tag); fill_state = 2'(st);
      @(negedge clk);
      fill_valid = 1'b0;
      if (ic) begin m_ist[set][way] = st; m_itag[set][way] = tag; end
      else    begin m_dst[set][way] = st; m_dtag[set][way] = tag; end
   endtask

   task automatic sweep(input string req);
      bit bad = 0;
      n_tests++;
      for (int ic = 0; ic < 2; ic++) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               int es, et;
               rd_icache = ic[0]; rd_set = SET_W'(s); rd_way = WAY_W'(w);
               #1;
               es = ic ? m_ist[s][w] : m_dst[s][w];
               et = ic ? m_itag[s][w] : m_dtag[s][w];
               if (!bad && (int'(rd_state) != es || (es != 0 && int'(rd_tag) != et))) begin
                  bad = 1;
                  n_fail++;
                  $display("FAIL %s array %0d set %0d way %0d: actual st %0h tag %0h expected st %0h tag %0h",
                           req, ic, s, w, rd_state, rd_tag, es, et);
               end
            end
         end
      end
   endtask

   task automatic run(input logic [1:0] op, input int tag, input int set, input bit bat,
                      input bit pte, input bit abe, input int dly, input bit junk, input string req);
      logic [ADDR_W-1:0] a, al;
      bit is_ic, flt, xwb, xbc;
      int hw, hst;
      a  = mk_addr(tag, set, 7);
      al = {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      is_ic = (op == C_IINV);
      flt = !is_ic && (bat || pte);
      hw = -1; hst = 0;
      if (!is_ic) begin
         for (int w = 0; w < WAYS; w++) begin
            if (hw < 0 && m_dst[set][w] != 0 && m_dtag[set][w] == tag) begin
               hw = w; hst = m_dst[set][w];
            end
         end
      end
      xwb = !is_ic && !flt && hw >= 0 && hst == 2;
      xbc = !is_ic && !flt && abe;

      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
      xlat_blk_fault = bat; xlat_page_fault = pte; addr_bcast_en = abe;
      @(negedge clk);
      xlat_blk_fault = 1'b0; xlat_page_fault = 1'b0; addr_bcast_en = !abe;
      if (junk) begin cmd_op = C_FLUSH; cmd_addr = mk_addr(TD, 6, 0); end
      else cmd_valid = 1'b0;
      chk({req, " R9"}, "busy after accept", busy, 1);
      chk(req, "done during lookup", done, 0);
      @(negedge clk);
      if (!xwb) cmd_valid = 1'b0;
      chk(req, "done after lookup", done, !xwb);
      chk(req, "wb_valid", wb_valid, xwb);
      chk(req, "busy after lookup", busy, xwb);
      chk(req, "exc_valid", exc_valid, flt);
      if (flt) chk({req, " R7"}, "exc_cause", exc_cause, bat ? 1 : 2);
      chk({req, " R6"}, "bcast_valid", bcast_valid, xbc);
      if (xbc) begin
         chk({req, " R6"}, "bcast_addr", bcast_addr, al);
         chk({req, " R6"}, "bcast_op", bcast_op, op);
      end
      if (xwb) begin
         chk(req, "wb_addr", wb_addr, al);
         for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk({req, " R10"}, "wb_valid held", wb_valid, 1);
            chk({req, " R10"}, "wb_addr held", wb_addr, al);
            chk({req, " R10"}, "no done while stalled", done, 0);
            rd_icache = 1'b0; rd_set = SET_W'(set); rd_way = WAY_W'(hw);
            #1;
            chk({req, " R10"}, "state before handshake", rd_state, 2);
         end
         wb_ready = 1'b1;
         cmd_valid = 1'b0;
         @(negedge clk);
         wb_ready = 1'b0;
         chk(req, "done after handshake", done, 1);
         chk(req, "busy after handshake", busy, 0);
         chk(req, "wb_valid after handshake", wb_valid, 0);
      end
      @(negedge clk);
      chk({req, " R9"}, "done one cycle", done, 0);
      chk({req, " R9"}, "idle after command", busy, 0);

      if (is_ic) begin
         for (int w = 0; w < WAYS; w++) m_ist[set][w] = 0;
      end else if (!flt && hw >= 0) begin
         if (hst == 2) m_dst[set][hw] = (op == C_STORE) ? 1 : 0;
         else if (hst == 1 && op == C_FLUSH) m_dst[set][hw] = 0;
      end
      sweep(req);
   endtask

   initial begin
      for (int s = 0; s < SETS; s++) begin
         for (int w = 0; w < WAYS; w++) begin
            m_dst[s][w] = 0; m_dtag[s][w] = 0; m_ist[s][w] = 0; m_itag[s][w] = 0;
         end
      end
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "wb_valid", wb_valid, 0);
      chk("R1", "bcast_valid", bcast_valid, 0);
      chk("R1", "exc_valid", exc_valid, 0);
      sweep("R1");

      fill(0, 2, 1, TA, 2);
      fill(0, 2, 3, TB, 1);
      fill(0, 5, 0, TC, 2);
      fill(0, 6, 2, TD, 2);
      fill(0, 1, 0, TA, 2);
      for (int w = 0; w < WAYS; w++) fill(1, 3, w, 24'h100 + w, 1);
      fill(1, 4, 0, 24'h200, 1);
      sweep("R1");

      run(C_STORE, TA, 2, 0, 0, 1, 2, 0, "R2");
      run(C_STORE, TB, 2, 0, 0, 0, 0, 0, "R3");
      run(C_STORE, TZ, 2, 0, 0, 1, 0, 0, "R3");
      run(C_FLUSH, TA, 2, 0, 0, 0, 0, 0, "R5");
      run(C_FLUSH, TC, 5, 0, 0, 1, 2, 1, "R9");
      run(C_FLUSH, TZ, 5, 0, 0, 1, 0, 0, "R5");
      run(C_FLUSH, TA, 1, 0, 0, 0, 1, 0, "R4");
      run(C_STORE, TD, 6, 1, 1, 1, 0, 0, "R7");
      run(C_FLUSH, TD, 6, 0, 1, 1, 0, 0, "R7");
      run(C_IINV, 24'h123456, 3, 1, 1, 1, 0, 0, "R8");

      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b11; cmd_addr = mk_addr(TD, 6, 0);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R11", "busy after reserved code", busy, 0);
      @(negedge clk);
      chk("R11", "done after reserved code", done, 0);
      sweep("R11");

      run(C_STORE, TD, 6, 0, 0, 0, 4, 0, "R10");
      run(C_STORE, TD, 6, 0, 0, 1, 0, 0, "R6");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule